// File: doc/BRIEF.md
# Shared-Window Push-Button Debouncer

This block cleans up three active-low push-button lines for a controller that samples them on a slow periodic tick. The raw lines first pass through a two-flop synchroniser. Whenever the confirmation window is idle and a tick arrives, the synchronised inputs are compared with the accepted (stable) value. If any line disagrees, the set of disagreeing lines is latched as a change mask, and one shared countdown is loaded with twelve ticks.

While that countdown runs, no new mask is taken. On the tick that brings the countdown to zero, only the lines in the mask are compared again. The lines that still disagree are toggled into the stable value, and a one-cycle report pulse tells a downstream message sender that a fresh button state is waiting. A line that returned to its accepted level inside the window is dropped without any trace. A line that changed after the window opened waits for the next idle tick. With a tick of about 0.8 ms, the window is roughly 10 ms.

Top module: `shared_window_debouncer`

## Requirements
- R1: While reset is asserted and after it is released, the stable output is all ones (no button pressed) and the report output is 0, until the first commit.
- R2: Every comparison uses the raw inputs delayed by two clock edges through a synchroniser whose flops reset to 1.
- R3: On a tick where the countdown is zero and the synchronised inputs differ from the stable value, the differing bits are captured as the mask and the countdown is loaded with 12. A change that lands while the window is busy is picked up on the first idle tick after the window closes.
- R4: While the countdown is nonzero it decrements by one on each tick and holds between ticks. No mask capture happens in that time, so a line that changes after arming is not committed when that window closes.
- R5: On the tick that brings the countdown from 1 to 0, exactly the masked bits whose synchronised value still differs from the stable value are toggled. All other bits keep their value.
- R6: The report output is high for exactly one clock, in the same cycle in which the stable output first shows a commit, and only when at least one bit was toggled.
- R7: A masked bit that has returned to its stable level by the closing tick is dropped without a report pulse. If the line changes again later, it can re-arm the window on a later idle tick.
- R8: A held press that is applied at least three clocks before a tick is reported on the 13th tick counted from the press: one tick arms the window and twelve more count it down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, about every 0.8 ms, that paces the confirmation window |
| btn_raw_i | input | 3 | Asynchronous active-low button lines |
| stable_o | output | 3 | Debounced button state, active low |
| report_o | output | 1 | One-cycle pulse each time the stable state changes |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe that is clocked and free of X values after reset. They make no assumption about how the raw buttons bounce, since the synchroniser absorbs any timing. The bench drives a free-running tick every five clocks. It changes the button lines only on falling clock edges and places every directed press right after a tick. This gives the synchroniser room, so the thirteen-tick latency is exact. A behavioural model with its own two-entry sample queue is checked against both outputs on every clock, through bounces, mid-window presses and partial commits.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
    localparam int unsigned DBN_LINES_DEFAULT   = 3;
    localparam int unsigned DBN_CONFIRM_DEFAULT = 12;
    localparam int unsigned DBN_SYNC_DEFAULT    = 2;

    function automatic int unsigned dbn_cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
    parameter int unsigned LINES  = dbn_pkg::DBN_LINES_DEFAULT,
    parameter int unsigned STAGES = dbn_pkg::DBN_SYNC_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    typedef struct packed {
        logic [LINES-1:0][STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int unsigned b = 0; b < LINES; b++) begin
            st_d.chain[b][0] = async_i[b];
            for (int unsigned s = 1; s < STAGES; s++) begin
                st_d.chain[b][s] = st_q.chain[b][s-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    for (genvar b = 0; b < LINES; b++) begin : g_out
        assign sync_o[b] = st_q.chain[b][STAGES-1];
    end

    // R2
    sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(rst_ni, 2)) |-> (sync_o == $past(async_i, STAGES)));
endmodule

// File: rtl/dbn_window_timer.sv
module dbn_window_timer #(
    parameter int unsigned CONFIRM = dbn_pkg::DBN_CONFIRM_DEFAULT,
    localparam int unsigned CW     = dbn_pkg::dbn_cnt_width(CONFIRM)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          arm_i,
    output logic          idle_o,
    output logic          expire_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [CW-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (st_q.count == '0) begin
                if (arm_i) st_d.count = CW'(CONFIRM);
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign idle_o   = (st_q.count == '0);
    assign expire_o = tick_i && (st_q.count == CW'(1));
    assign count_o  = st_q.count;

    // R3
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CW'(CONFIRM));

    // R3
    load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_o && arm_i && tick_i) |=> (count_o == CW'(CONFIRM)));

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(count_o));

    // R4
    step_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !idle_o) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/dbn_commit_unit.sv
module dbn_commit_unit #(
    parameter int unsigned LINES = dbn_pkg::DBN_LINES_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             idle_i,
    input  logic             expire_i,
    input  logic [LINES-1:0] sync_i,
    output logic             arm_o,
    output logic [LINES-1:0] stable_o,
    output logic             report_o
);
    typedef struct packed {
        logic [LINES-1:0] stable;
        logic [LINES-1:0] mask;
        logic             report;
    } cmt_state_t;

    localparam cmt_state_t RESET_ST = '{stable: '1, mask: '0, report: 1'b0};

    cmt_state_t       st_d, st_q;
    logic [LINES-1:0] diff;
    logic [LINES-1:0] flips;

    assign diff  = sync_i ^ st_q.stable;
    assign flips = diff & st_q.mask;
    assign arm_o = tick_i && idle_i && (diff != '0);

    always_comb begin
        st_d        = st_q;
        st_d.report = 1'b0;
        if (arm_o) begin
            st_d.mask = diff;
        end else if (expire_i) begin
            st_d.stable = st_q.stable ^ flips;
            st_d.report = (flips != '0);
            st_d.mask   = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RESET_ST;
        else         st_q <= st_d;
    end

    assign stable_o = st_q.stable;
    assign report_o = st_q.report;

    // R5
    masked_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stable_o ^ $past(stable_o)) & ~$past(st_q.mask)) == '0);

    // R6
    report_pairs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        report_o |-> (stable_o != $past(stable_o)));

    // R6
    report_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        report_o |=> !report_o);

    // R4
    no_capture_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idle_i && !expire_i) |=> $stable(st_q.mask));
endmodule

// File: rtl/shared_window_debouncer.sv
module shared_window_debouncer #(
    parameter int unsigned LINES   = dbn_pkg::DBN_LINES_DEFAULT,
    parameter int unsigned CONFIRM = dbn_pkg::DBN_CONFIRM_DEFAULT,
    parameter int unsigned STAGES  = dbn_pkg::DBN_SYNC_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [LINES-1:0] btn_raw_i,
    output logic [LINES-1:0] stable_o,
    output logic             report_o
);
    localparam int unsigned CW = dbn_pkg::dbn_cnt_width(CONFIRM);

    logic [LINES-1:0] btn_sync;
    logic             arm;
    logic             idle;
    logic             expire;
    logic [CW-1:0]    count;

    dbn_sync #(.LINES(LINES), .STAGES(STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (btn_raw_i),
        .sync_o  (btn_sync)
    );

    dbn_window_timer #(.CONFIRM(CONFIRM)) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .arm_i    (arm),
        .idle_o   (idle),
        .expire_o (expire),
        .count_o  (count)
    );

    dbn_commit_unit #(.LINES(LINES)) i_commit (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .idle_i   (idle),
        .expire_i (expire),
        .sync_i   (btn_sync),
        .arm_o    (arm),
        .stable_o (stable_o),
        .report_o (report_o)
    );

    // R8
    commit_at_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stable_o != $past(stable_o)) |-> $past(expire));

    // R3
    arm_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count != '0 && $past(count) == '0) |-> $past(tick_i));
endmodule

// File: tb/test_shared_window_debouncer.sv
module test_shared_window_debouncer;
    localparam int TICK_DIV = 5;
    localparam int WINDOW   = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] raw = 3'b111;
    logic [2:0] stable;
    logic       report;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int pulse_cnt = 0;
    int div = 0;
    bit done = 0;

    bit [2:0] q_pipe[$];
    bit [2:0] m_stable = 3'b111;
    bit [2:0] m_mask = 3'b000;
    int       m_cnt = 0;
    bit       m_rep = 0;

    always #5 clk = ~clk;

    shared_window_debouncer i_shared_window_debouncer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .btn_raw_i (raw),
        .stable_o  (stable),
        .report_o  (report)
    );

    always @(negedge clk) begin
        if (div == TICK_DIV - 1) begin div <= 0; tick <= 1'b1; end
        else begin div <= div + 1; tick <= 1'b0; end
    end

    always @(posedge clk) begin
        bit [2:0] seen;
        bit [2:0] t;
        if (!rst_n) begin
            q_pipe = {3'b111, 3'b111};
            m_stable = 3'b111; m_mask = 0; m_cnt = 0; m_rep = 0;
        end else begin
            seen  = q_pipe[0];
            m_rep = 0;
            if (tick) begin
                tick_cnt++;
                if (m_cnt == 0) begin
                    if ((seen ^ m_stable) != 0) begin
                        m_mask = seen ^ m_stable;
                        m_cnt  = WINDOW;
                    end
                end else begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        t = (seen ^ m_stable) & m_mask;
                        m_stable ^= t;
                        m_rep = (t != 0);
                        m_mask = 0;
                    end
                end
            end
            q_pipe.push_back(raw);
            void'(q_pipe.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (stable !== m_stable || report !== m_rep) begin
                errors++;
                $display("FAIL R2 R5 R6 model: stable=%b report=%b expected stable=%b report=%b",
                         stable, report, m_stable, m_rep);
            end
            if (report === 1'b1) pulse_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic after_tick();
        @(posedge clk);
        while (!tick) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) after_tick();
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (report === 1'b1) return;
        end
    endtask

    initial begin
        int t0;
        int p0;
        repeat (4) @(negedge clk);
        check("R1 stable in reset", int'(stable), 7);
        check("R1 report in reset", int'(report), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 stable after reset", int'(stable), 7);

        // R8, R3: held press of line 0
        after_tick();
        t0 = tick_cnt; raw = 3'b110;
        wait_pulse();
        check("R8 ticks to report", tick_cnt - t0, WINDOW + 1);
        check("R3 line0 committed", int'(stable), 6);
        @(negedge clk);
        check("R6 pulse one cycle", int'(report), 0);

        // R7: line 1 bounces back inside window
        after_tick();
        p0 = pulse_cnt; raw = 3'b100;
        wait_ticks(3);
        raw = 3'b110;
        wait_ticks(16);
        check("R7 bounce dropped stable", int'(stable), 6);
        check("R7 bounce no pulse", pulse_cnt - p0, 0);
        raw = 3'b100;
        wait_pulse();
        check("R7 re-arm after drop", int'(stable), 4);

        // R4: line 2 changes after arming
        after_tick();
        raw = 3'b101;
        wait_ticks(2);
        raw = 3'b001;
        wait_pulse();
        check("R4 late change not committed", int'(stable), 5);
        @(negedge clk);
        wait_pulse();
        check("R3 late change committed next window", int'(stable), 1);

        // R5: partial commit
        after_tick();
        p0 = pulse_cnt; raw = 3'b110;
        wait_ticks(3);
        raw = 3'b111;
        wait_pulse();
        check("R5 only still-differing bits toggle", int'(stable), 7);
        wait_ticks(16);
        check("R5 no further commit", pulse_cnt - p0, 1);
        check("R5 stable held", int'(stable), 7);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule